// File: doc/BRIEF.md
# USART Baud and Clock Enable Generator

This block creates the bit-timing strobes for a serial transceiver. A divisor counter runs on the system clock and emits one tick every divisor + 1 cycles. The receiver base enable is that tick, undivided. The transmitter enable is the tick reduced by a post-divider. The post-divider ratio depends on the selected mode: asynchronous at normal speed, asynchronous at double speed, or synchronous master.

In synchronous slave operation the internal counter no longer sets the timing. An external serial clock passes through a synchroniser, and the polarity input selects which of its edges produces the transmit and receive enables. In synchronous master operation the block drives the external clock pin with a square wave built from the counter ticks. The block also reports how many oversampling states the receiver's recovery logic must use.

All outputs are single-cycle enables in the system clock domain.

Top module: `usart_clkgen`

## Requirements
- R1: While rst_ni is low, rxclk_en_o, txclk_en_o and xck_o are all 0.
- R2: Outside slave mode, rxclk_en_o is a one-cycle pulse that repeats every D+1 system cycles, where D is div_i. With D=0 it is high on every cycle, and D=4095 gives 4096 cycles.
- R3: A high div_lo_wr_i reloads the counter from div_i on that clock edge. The next rxclk_en_o pulse is sampled D+1 cycles after the cycle in which the strobe was driven.
- R4: In asynchronous mode (sync_mode_i=0), txclk_en_o repeats every 16(D+1) cycles when dbl_speed_i=0 and every 8(D+1) cycles when dbl_speed_i=1.
- R5: In synchronous master mode (sync_mode_i=1, xck_dir_i=1), txclk_en_o repeats every 2(D+1) cycles, and dbl_speed_i has no effect.
- R6: os_count_o is binary 16 for asynchronous normal speed, 8 for asynchronous double speed, and 2 whenever sync_mode_i=1, whatever the value of dbl_speed_i.
- R7: xck_oe_o is 1 only in master mode. xck_o is 0 outside master mode. In master mode xck_o toggles on every counter tick, so each of its levels lasts D+1 cycles.
- R8: In slave mode (sync_mode_i=1, xck_dir_i=0), every rising edge of xck_i (xck_pol_i=0) or every falling edge (xck_pol_i=1) gives exactly one one-cycle pulse, raised on txclk_en_o and rxclk_en_o together. The other edge gives no pulse.
- R9: In slave mode, the pulse is visible in the second system cycle after the cycle in which xck_i changed. This latency comes from a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 12 | Baud divisor D |
| div_lo_wr_i | input | 1 | Low-byte write strobe, forces a counter reload |
| sync_mode_i | input | 1 | 1 selects synchronous operation |
| dbl_speed_i | input | 1 | 1 selects double speed (asynchronous mode only) |
| xck_dir_i | input | 1 | External clock pin direction: 1 = output (master), 0 = input (slave) |
| xck_pol_i | input | 1 | Slave edge select: 0 = rising, 1 = falling |
| xck_i | input | 1 | External clock pin input |
| txclk_en_o | output | 1 | Transmitter clock enable |
| rxclk_en_o | output | 1 | Receiver base clock enable |
| xck_o | output | 1 | External clock pin output value |
| xck_oe_o | output | 1 | External clock pin output enable |
| os_count_o | output | 5 | Oversampling state count for the receiver |

## Verification
The bench builds the block with the default 12-bit divisor width. This allows the full-scale divisor 4095 to be timed directly, together with the degenerate divisor 0, where the receiver enable never drops. Small divisors of 2 to 5 keep the 16x and 8x transmitter periods short. This allows all of the following to be timed in one run: every mode, a mid-count reload, the master pin waveform, and both slave edge polarities.

// File: rtl/usart_clkgen_pkg.sv
package usart_clkgen_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC  = 2'd0,
    MODE_DOUBLE = 2'd1,
    MODE_MASTER = 2'd2,
    MODE_SLAVE  = 2'd3
  } clk_mode_e;

  localparam int unsigned OS_W = 5;
endpackage

// File: rtl/usart_baud_counter.sv
module usart_baud_counter #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             load_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (load_i || cnt_q == '0) cnt_q <= div_i;
      else                       cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick_o = run_q && (cnt_q == '0);

  // R2: with a nonzero divisor and no reload, ticks never come back to back
  a_r2_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0 && !load_i) |=> !tick_o);
endmodule

// File: rtl/usart_tx_divider.sv
module usart_tx_divider #(
  parameter int unsigned PD_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [PD_W-1:0] mask_i,
  output logic            tx_en_o
);
  logic [PD_W-1:0] pdiv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pdiv_q <= '0;
    else if (tick_i) pdiv_q <= pdiv_q + 1'b1;
  end

  // ratio = mask + 1 (mask is 1, 7 or 15)
  assign tx_en_o = tick_i && ((pdiv_q & mask_i) == mask_i);

  // R4: ratio is at least two, so transmitter enables never come back to back
  a_r4_tx_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o && mask_i != '0) |=> !tx_en_o);
endmodule

// File: rtl/usart_xck_edge.sv
module usart_xck_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xck_i,
  input  logic pol_i,
  output logic edge_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= xck_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_o = pol_i ? (!s2_q && s3_q) : (s2_q && !s3_q);

  // R8: one pulse per external edge
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen
  import usart_clkgen_pkg::*;
#(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             div_lo_wr_i,
  input  logic             sync_mode_i,
  input  logic             dbl_speed_i,
  input  logic             xck_dir_i,
  input  logic             xck_pol_i,
  input  logic             xck_i,
  output logic             txclk_en_o,
  output logic             rxclk_en_o,
  output logic             xck_o,
  output logic             xck_oe_o,
  output logic [OS_W-1:0]  os_count_o
);
  localparam int unsigned PD_W = 4;

  clk_mode_e       mode;
  logic            tick, tx_div, slave_edge, xck_q;
  logic [PD_W-1:0] pd_mask;

  always_comb begin
    if (!sync_mode_i) mode = dbl_speed_i ? MODE_DOUBLE : MODE_ASYNC;
    else              mode = xck_dir_i   ? MODE_MASTER : MODE_SLAVE;
  end

  always_comb begin
    unique case (mode)
      MODE_ASYNC:  begin pd_mask = 4'd15; os_count_o = 5'd16; end
      MODE_DOUBLE: begin pd_mask = 4'd7;  os_count_o = 5'd8;  end
      default:     begin pd_mask = 4'd1;  os_count_o = 5'd2;  end
    endcase
  end

  usart_baud_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i),
    .load_i(div_lo_wr_i), .tick_o(tick)
  );

  usart_tx_divider #(.PD_W(PD_W)) u_pdiv (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .mask_i(pd_mask), .tx_en_o(tx_div)
  );

  usart_xck_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .xck_i(xck_i),
    .pol_i(xck_pol_i), .edge_o(slave_edge)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   xck_q <= 1'b0;
    else if (tick) xck_q <= !xck_q;
  end

  assign rxclk_en_o = (mode == MODE_SLAVE) ? slave_edge : tick;
  assign txclk_en_o = (mode == MODE_SLAVE) ? slave_edge : tx_div;
  assign xck_oe_o   = (mode == MODE_MASTER);
  assign xck_o      = (mode == MODE_MASTER) && xck_q;

  // R7: pin is neither driven nor toggled in asynchronous mode
  a_r7_async_pin_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_mode_i |-> (!xck_oe_o && !xck_o));
  // R4: in asynchronous modes every transmit enable coincides with a receive enable
  a_r4_tx_on_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txclk_en_o && !sync_mode_i) |-> rxclk_en_o);
  // R8: in slave mode both enables move together
  a_r8_slave_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && !xck_dir_i) |-> (txclk_en_o == rxclk_en_o));
  // R6: exactly one of the legal counts 16, 8 or 2
  a_r6_os_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(os_count_o) == 1);
endmodule

// File: tb/usart_clkgen_bench.sv
`timescale 1ns/1ps
module usart_clkgen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] div = 12'd3;
  logic        wr = 1'b0, sync_m = 1'b0, dbl = 1'b0, dir = 1'b0, pol = 1'b0, xck_in = 1'b0;
  logic        tx_en, rx_en, xck_out, xck_oe;
  logic [4:0]  os_cnt;
  int          checks = 0, errors = 0, cyc = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  usart_clkgen u_usart_clkgen (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .div_lo_wr_i(wr),
    .sync_mode_i(sync_m), .dbl_speed_i(dbl), .xck_dir_i(dir), .xck_pol_i(pol),
    .xck_i(xck_in), .txclk_en_o(tx_en), .rxclk_en_o(rx_en),
    .xck_o(xck_out), .xck_oe_o(xck_oe), .os_count_o(os_cnt)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_div(input int d);
    @(negedge clk); div = d[11:0]; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  // sel 0: rx, 1: tx, 2: xck_o change
  task automatic measure(input int sel, output int n);
    logic prev, hit;
    int   seen;
    prev = xck_out;
    seen = 0;
    n = 0;
    while (seen < 2 && n < 70000) begin
      @(negedge clk);
      case (sel)
        0:       hit = rx_en;
        1:       hit = tx_en;
        default: hit = (xck_out != prev);
      endcase
      prev = xck_out;
      if (seen == 1) n++;
      if (hit) seen++;
    end
  endtask

  task automatic t_reset();
    sync_m = 1'b1; dir = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 rx in reset", rx_en, 0);
    check("R1 tx in reset", tx_en, 0);
    check("R1 xck in reset", xck_out, 0);
    sync_m = 1'b0; dir = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic t_rx_period();
    int n;
    set_div(3);    measure(0, n); check("R2 rx period D=3", n, 4);
    set_div(0);    measure(0, n); check("R2 rx period D=0", n, 1);
    set_div(4095); measure(0, n); check("R2 rx period D=4095", n, 4096);
  endtask

  task automatic t_reload();
    int n;
    set_div(200);
    measure(0, n);
    repeat (10) @(negedge clk);
    div = 12'd5; wr = 1'b1;
    n = 0;
    do begin
      @(negedge clk); wr = 1'b0; n++;
    end while (!rx_en && n < 400);
    check("R3 first pulse after reload", n, 6);
    measure(0, n); check("R3 period after reload", n, 6);
  endtask

  task automatic t_async_tx();
    int n;
    sync_m = 1'b0; dbl = 1'b0;
    set_div(2); measure(1, n); check("R4 tx normal", n, 48);
    check("R6 os normal", os_cnt, 16);
    dbl = 1'b1; measure(1, n); measure(1, n); check("R4 tx double", n, 24);
    check("R6 os double", os_cnt, 8);
    check("R7 oe async", xck_oe, 0);
    check("R7 xck async", xck_out, 0);
  endtask

  task automatic t_master();
    int n;
    sync_m = 1'b1; dir = 1'b1; dbl = 1'b1;
    set_div(3);
    measure(1, n); measure(1, n); check("R5 tx master dbl=1", n, 8);
    dbl = 1'b0; measure(1, n); measure(1, n); check("R5 tx master dbl=0", n, 8);
    check("R6 os sync", os_cnt, 2);
    dbl = 1'b1; @(negedge clk); check("R6 os sync dbl", os_cnt, 2);
    check("R7 oe master", xck_oe, 1);
    measure(2, n); check("R7 xck half period", n, 4);
  endtask

  task automatic t_slave(input logic p);
    int cnt, mism;
    logic lvl, want;
    sync_m = 1'b1; dir = 1'b0; pol = p;
    set_div(0);
    repeat (4) @(negedge clk);
    check("R7 oe slave", xck_oe, 0);
    mism = 0;
    for (int i = 0; i < 6; i++) begin
      lvl = (i % 2 == 0);
      want = (lvl != p);
      @(negedge clk); xck_in = lvl;
      cnt = 0;
      for (int k = 1; k <= 10; k++) begin
        @(negedge clk);
        if (rx_en) cnt++;
        if (tx_en != rx_en) mism++;
        if (k == 2) check($sformatf("R9 latency pol=%0d", p), rx_en, int'(want));
      end
      check($sformatf("R8 pulses pol=%0d lvl=%0d", p, lvl), cnt, int'(want));
    end
    check("R8 tx equals rx", mism, 0);
  endtask

  initial begin
    t_reset();
    t_rx_period();
    t_reload();
    t_async_tx();
    t_master();
    t_slave(1'b0);
    t_slave(1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule